// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block chooses which pending interrupt the processor takes next. There are three groups of sources. Four backplane request lines cover external levels 4 through 7. Three on-board sources (console line, programmable timers and doorbell) share level hex 14. An interval timer has its own line. The block holds the processor priority level in a register. A request is eligible only when its level is strictly above that register, and the highest eligible request wins under one fixed ranking.

When a grant is made, the block latches the identity of the winner and raises the priority register. An external level lifts it to hex 17, so every backplane line is masked until software lowers it. The interval timer lifts it to hex 16, which leaves level 7 enabled. An on-board source lifts it to hex 14. An external grant then runs a two-phase bus handshake: a data-in phase followed by an acknowledge phase, each closed by a completion strobe. An on-board or timer grant needs no bus phase and completes in one cycle. Software loads the priority register through a write port whenever no grant is in progress.

Top module: `ipl_arb`

## Requirements
- R1: While reset is held and after it is released, gnt_valid, din_o and iak_o are low and ipl_o holds hex 1F.
- R2: A source is eligible only when its level is strictly greater than ipl_o. External line k (k = 0..3) has level hex 14+k, the three on-board sources have level hex 14 and the interval timer has level hex 16. When no request is eligible, no grant is made and ipl_o is unchanged.
- R3: gnt_id encodes the winner as follows: 0 to 3 are external levels 4 to 7, 4 is the console, 5 is the timers, 6 is the doorbell and 7 is the interval timer. The ranking, highest first, is: external level 7, interval timer, external level 6, external level 5, on-board sources, external level 4.
- R4: Among on-board sources that request together, the console beats the timers and the timers beat the doorbell.
- R5: An external grant sets ipl_o to hex 17 in the cycle in which gnt_valid rises.
- R6: An interval timer grant sets ipl_o to hex 16. A later external level-7 request is still granted, and an external level-6 request is not.
- R7: An on-board grant sets ipl_o to hex 14.
- R8: An external grant raises din_o together with gnt_valid. The first phase_done moves the handshake to iak_o. The second phase_done ends the grant. An on-board or timer grant holds gnt_valid for exactly one cycle, with din_o and iak_o low.
- R9: gnt_id stays constant while gnt_valid is high. Requests are not sampled while gnt_valid is high, and gnt_valid is low for at least one cycle between grants.
- R10: A sw_wr in a cycle with gnt_valid low loads sw_ipl into ipl_o at the next edge, and no grant is made in that cycle. A sw_wr while gnt_valid is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 4 | Backplane requests, bit k = level 4+k |
| int_req | input | 3 | On-board requests: console, timers, doorbell |
| itmr_req | input | 1 | Interval timer request |
| sw_wr | input | 1 | Software priority write strobe |
| sw_ipl | input | 5 | Priority value to write |
| phase_done | input | 1 | Completion strobe for the current bus phase |
| gnt_valid | output | 1 | A grant is in progress |
| gnt_id | output | 3 | Identity of the granted source |
| ipl_o | output | 5 | Processor priority level register |
| din_o | output | 1 | Data-in phase of the external handshake |
| iak_o | output | 1 | Acknowledge phase of the external handshake |

## Verification
The bench sweeps all 256 request patterns against seven priority levels. The levels sit on both sides of every source level, so a comparison written as "greater or equal" would grant sources at exactly the current level, and a misplaced interval timer or on-board group would pick the wrong id. The bench checks the priority level written after each kind of grant: a design that raised it to 17 after a timer grant would lose the level-7 re-grant. It also checks the exact phase count of each handshake, and that a priority write made during a handshake is dropped. A design that let new requests or writes through mid-grant would change gnt_id or ipl_o.

// File: rtl/ipl_arb_pkg.sv
package ipl_arb_pkg;
   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_LOCAL = 2'd1,
      HS_DIN   = 2'd2,
      HS_IAK   = 2'd3
   } hs_state_e;
endpackage

// File: rtl/ipl_elig.sv
module ipl_elig #(
   parameter int N_EXT        = 4,
   parameter int N_INT        = 3,
   parameter int IPL_W        = 5,
   parameter int EXT_BASE_LVL = 'h14,
   parameter int INT_LVL      = 'h14,
   parameter int ITMR_LVL     = 'h16,
   localparam int S           = N_EXT + N_INT + 1
) (
   input  logic [N_EXT-1:0] ext_req,
   input  logic [N_INT-1:0] int_req,
   input  logic             itmr_req,
   input  logic [IPL_W-1:0] ipl,
   output logic [S-1:0]     ok
);
   localparam logic [IPL_W-1:0] INT_L  = IPL_W'(INT_LVL);
   localparam logic [IPL_W-1:0] ITMR_L = IPL_W'(ITMR_LVL);

   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      localparam logic [IPL_W-1:0] LV = IPL_W'(EXT_BASE_LVL + i);
      assign ok[i] = ext_req[i] && (LV > ipl);
   end

   for (genvar k = 0; k < N_INT; k++) begin : g_int
      assign ok[N_EXT+k] = int_req[k] && (INT_L > ipl);
   end

   assign ok[S-1] = itmr_req && (ITMR_L > ipl);
endmodule

// File: rtl/ipl_pick.sv
module ipl_pick #(
   parameter int N_EXT = 4,
   parameter int N_INT = 3,
   localparam int S    = N_EXT + N_INT + 1,
   localparam int ID_W = $clog2(S)
) (
   input  logic [S-1:0]    ok,
   output logic            win_vld,
   output logic [ID_W-1:0] win_id
);
   // rank 0 is highest: top external, timer, remaining externals
   // downward except the lowest, on-board sources, lowest external
   function automatic int rank_id(int r);
      if (r == 0)          return N_EXT - 1;
      else if (r == 1)     return S - 1;
      else if (r < N_EXT)  return N_EXT - r;
      else if (r < S - 1)  return r;
      else                 return 0;
   endfunction

   always_comb begin
      win_vld = 1'b0;
      win_id  = '0;
      for (int r = S - 1; r >= 0; r--) begin
         if (ok[rank_id(r)]) begin
            win_vld = 1'b1;
            win_id  = ID_W'(rank_id(r));
         end
      end
   end
endmodule

// File: rtl/ipl_ack_fsm.sv
module ipl_ack_fsm
   import ipl_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_ext,
   input  logic phase_done,
   output logic busy,
   output logic din,
   output logic iak
);
   hs_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HS_IDLE:  if (start) st_d = start_ext ? HS_DIN : HS_LOCAL;
         HS_LOCAL: st_d = HS_IDLE;
         HS_DIN:   if (phase_done) st_d = HS_IAK;
         HS_IAK:   if (phase_done) st_d = HS_IDLE;
         default:  st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= HS_IDLE;
      else        st_q <= st_d;
   end

   assign busy = (st_q != HS_IDLE);
   assign din  = (st_q == HS_DIN);
   assign iak  = (st_q == HS_IAK);
endmodule

// File: rtl/ipl_arb.sv
module ipl_arb #(
   parameter int N_EXT         = 4,
   parameter int N_INT         = 3,
   parameter int IPL_W         = 5,
   parameter int EXT_BASE_LVL  = 'h14,
   parameter int INT_LVL       = 'h14,
   parameter int ITMR_LVL      = 'h16,
   parameter int EXT_GRANT_LVL = 'h17,
   parameter int RESET_IPL     = 'h1F,
   localparam int S            = N_EXT + N_INT + 1,
   localparam int ID_W         = $clog2(S)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_req,
   input  logic [N_INT-1:0] int_req,
   input  logic             itmr_req,
   input  logic             sw_wr,
   input  logic [IPL_W-1:0] sw_ipl,
   input  logic             phase_done,
   output logic             gnt_valid,
   output logic [ID_W-1:0]  gnt_id,
   output logic [IPL_W-1:0] ipl_o,
   output logic             din_o,
   output logic             iak_o
);
   localparam logic [IPL_W-1:0] EXT_G  = IPL_W'(EXT_GRANT_LVL);
   localparam logic [IPL_W-1:0] ITMR_G = IPL_W'(ITMR_LVL);
   localparam logic [IPL_W-1:0] INT_G  = IPL_W'(INT_LVL);

   if (N_EXT < 2) begin : g_bad_ext
      $error("ipl_arb: N_EXT must be at least 2");
   end
   if (N_INT < 1) begin : g_bad_int
      $error("ipl_arb: N_INT must be at least 1");
   end
   if (EXT_GRANT_LVL >= (1 << IPL_W) || RESET_IPL >= (1 << IPL_W)
       || EXT_BASE_LVL + N_EXT > (1 << IPL_W)) begin : g_bad_w
      $error("ipl_arb: levels do not fit IPL_W");
   end

   logic [S-1:0]     ok;
   logic             win_vld;
   logic [ID_W-1:0]  win_id;
   logic [IPL_W-1:0] ipl_q, new_ipl;
   logic [ID_W-1:0]  gnt_id_q;
   logic             busy, start, win_ext;

   ipl_elig #(
      .N_EXT(N_EXT), .N_INT(N_INT), .IPL_W(IPL_W),
      .EXT_BASE_LVL(EXT_BASE_LVL), .INT_LVL(INT_LVL), .ITMR_LVL(ITMR_LVL)
   ) elig_i (
      .ext_req(ext_req), .int_req(int_req), .itmr_req(itmr_req),
      .ipl(ipl_q), .ok(ok)
   );

   ipl_pick #(.N_EXT(N_EXT), .N_INT(N_INT)) pick_i (
      .ok(ok), .win_vld(win_vld), .win_id(win_id)
   );

   assign win_ext = (int'(win_id) < N_EXT);
   assign start   = !busy && !sw_wr && win_vld;

   always_comb begin
      if (win_ext)                   new_ipl = EXT_G;
      else if (int'(win_id) == S-1)  new_ipl = ITMR_G;
      else                           new_ipl = INT_G;
   end

   ipl_ack_fsm hs_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_ext(win_ext),
      .phase_done(phase_done), .busy(busy), .din(din_o), .iak(iak_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipl_q    <= IPL_W'(RESET_IPL);
         gnt_id_q <= '0;
      end else if (!busy) begin
         if (sw_wr) begin
            ipl_q <= sw_ipl;
         end else if (win_vld) begin
            ipl_q    <= new_ipl;
            gnt_id_q <= win_id;
         end
      end
   end

   assign gnt_valid = busy;
   assign gnt_id    = gnt_id_q;
   assign ipl_o     = ipl_q;
endmodule

// File: rtl/ipl_arb_chk.sv
module ipl_arb_chk #(
   parameter int N_EXT         = 4,
   parameter int N_INT         = 3,
   parameter int IPL_W         = 5,
   parameter int EXT_BASE_LVL  = 'h14,
   parameter int INT_LVL       = 'h14,
   parameter int ITMR_LVL      = 'h16,
   parameter int EXT_GRANT_LVL = 'h17,
   localparam int S            = N_EXT + N_INT + 1,
   localparam int ID_W         = $clog2(S)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_wr,
   input logic [IPL_W-1:0] sw_ipl,
   input logic             gnt_valid,
   input logic [ID_W-1:0]  gnt_id,
   input logic [IPL_W-1:0] ipl_o,
   input logic             din_o,
   input logic             iak_o
);
   function automatic int lvl_of(logic [ID_W-1:0] id);
      if (int'(id) < N_EXT)  return EXT_BASE_LVL + int'(id);
      if (int'(id) == S - 1) return ITMR_LVL;
      return INT_LVL;
   endfunction

   assert_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> (lvl_of(gnt_id) > int'($past(ipl_o))));

   assert_ext_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(din_o) |-> (int'(ipl_o) == EXT_GRANT_LVL));

   assert_phases_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(din_o && iak_o));

   assert_iak_after_din_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iak_o) |-> $past(din_o));

   assert_local_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !din_o && !iak_o) |=> !gnt_valid);

   assert_id_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && $past(gnt_valid)) |-> $stable(gnt_id));

   assert_sw_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !gnt_valid) |=> (ipl_o == $past(sw_ipl)));

   assert_sw_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && $past(gnt_valid)) |-> $stable(ipl_o));
endmodule

bind ipl_arb ipl_arb_chk #(
   .N_EXT(N_EXT), .N_INT(N_INT), .IPL_W(IPL_W),
   .EXT_BASE_LVL(EXT_BASE_LVL), .INT_LVL(INT_LVL), .ITMR_LVL(ITMR_LVL),
   .EXT_GRANT_LVL(EXT_GRANT_LVL)
) chk_i (
   .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_ipl(sw_ipl),
   .gnt_valid(gnt_valid), .gnt_id(gnt_id), .ipl_o(ipl_o),
   .din_o(din_o), .iak_o(iak_o)
);

// File: tb/ipl_arb_tb.sv
module ipl_arb_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ext_req = '0;
   logic [2:0] int_req = '0;
   logic       itmr_req = 1'b0;
   logic       sw_wr = 1'b0;
   logic [4:0] sw_ipl = '0;
   logic       phase_done = 1'b0;
   logic       gnt_valid;
   logic [2:0] gnt_id;
   logic [4:0] ipl_o;
   logic       din_o, iak_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ipl_arb dut_i (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
      .itmr_req(itmr_req), .sw_wr(sw_wr), .sw_ipl(sw_ipl),
      .phase_done(phase_done), .gnt_valid(gnt_valid), .gnt_id(gnt_id),
      .ipl_o(ipl_o), .din_o(din_o), .iak_o(iak_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // winner by score: level*8 plus a tie-break among equal levels
   function automatic int exp_win(logic [7:0] pat, int lvl);
      int best = -1;
      int bs = -1;
      for (int k = 0; k < 4; k++) begin
         if (pat[k] && (20 + k > lvl) && ((20 + k) * 8 > bs)) begin
            bs = (20 + k) * 8; best = k;
         end
      end
      for (int j = 0; j < 3; j++) begin
         if (pat[4+j] && (20 > lvl) && (20 * 8 + 3 - j > bs)) begin
            bs = 20 * 8 + 3 - j; best = 4 + j;
         end
      end
      if (pat[7] && (22 > lvl) && (22 * 8 + 5 > bs)) begin
         bs = 22 * 8 + 5; best = 7;
      end
      return best;
   endfunction

   function automatic int exp_ipl(int id);
      if (id < 4)  return 'h17;
      if (id == 7) return 'h16;
      return 'h14;
   endfunction

   task automatic set_req(input logic [7:0] pat);
      ext_req  = pat[3:0];
      int_req  = pat[6:4];
      itmr_req = pat[7];
   endtask

   task automatic load_ipl(input int lvl);
      @(negedge clk);
      set_req('0);
      sw_wr = 1'b1; sw_ipl = 5'(lvl);
      @(negedge clk);
      sw_wr = 1'b0;
      chk(ipl_o == 5'(lvl), "R10 load", ipl_o, lvl);
   endtask

   // finish a grant already observed; ext selects the bus handshake
   task automatic finish_grant(input bit ext, input int id);
      if (ext) begin
         phase_done = 1'b1;
         @(negedge clk);
         phase_done = 1'b0;
         chk(iak_o && !din_o, "R8 iak phase", {din_o, iak_o}, 1);
         chk(gnt_id == 3'(id), "R9 id stable", gnt_id, id);
         phase_done = 1'b1;
         @(negedge clk);
         phase_done = 1'b0;
      end else begin
         @(negedge clk);
      end
      chk(!gnt_valid, "R8 end of grant", gnt_valid, 0);
   endtask

   task automatic run_case(input int lvl, input logic [7:0] pat);
      int w;
      load_ipl(lvl);
      set_req(pat);
      @(negedge clk);
      set_req('0);
      w = exp_win(pat, lvl);
      if (w < 0) begin
         chk(!gnt_valid, "R2 no grant", gnt_valid, 0);
         chk(ipl_o == 5'(lvl), "R2 ipl kept", ipl_o, lvl);
      end else begin
         chk(gnt_valid, "R2 grant", gnt_valid, 1);
         chk(gnt_id == 3'(w), (w >= 4 && w <= 6) ? "R4 on-board order" : "R3 ranking", gnt_id, w);
         chk(ipl_o == 5'(exp_ipl(w)), w < 4 ? "R5 ext ipl" : (w == 7 ? "R6 timer ipl" : "R7 on-board ipl"),
             ipl_o, exp_ipl(w));
         chk(din_o == (w < 4) && !iak_o, "R8 first phase", {din_o, iak_o}, (w < 4) ? 2 : 0);
         finish_grant(w < 4, w);
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int lvls[7] = '{0, 'h13, 'h14, 'h15, 'h16, 'h17, 'h1F};
      repeat (3) @(negedge clk);
      chk(!gnt_valid && !din_o && !iak_o, "R1 outputs in reset", {gnt_valid, din_o, iak_o}, 0);
      chk(ipl_o == 5'h1F, "R1 ipl in reset", ipl_o, 'h1F);
      rst_n = 1'b1;
      set_req(8'hFF);
      @(negedge clk);
      chk(!gnt_valid, "R1 masked after reset", gnt_valid, 0);
      chk(ipl_o == 5'h1F, "R1 ipl after reset", ipl_o, 'h1F);

      foreach (lvls[i]) begin
         for (int p = 0; p < 256; p++) run_case(lvls[i], 8'(p));
      end

      // R6: timer grant leaves level 7 open, level 6 closed
      load_ipl(0);
      set_req(8'h80);
      @(negedge clk);
      set_req('0);
      chk(gnt_id == 3'd7 && ipl_o == 5'h16, "R6 timer grant", {gnt_id, ipl_o}, {3'd7, 5'h16});
      finish_grant(1'b0, 7);
      set_req(8'h04);
      @(negedge clk);
      chk(!gnt_valid, "R6 level 6 masked", gnt_valid, 0);
      set_req(8'h08);
      @(negedge clk);
      set_req('0);
      chk(gnt_valid && gnt_id == 3'd3, "R6 level 7 still open", gnt_id, 3);
      chk(ipl_o == 5'h17, "R5 after level 7", ipl_o, 'h17);

      // R9/R10: requests and writes ignored mid-handshake
      sw_wr = 1'b1; sw_ipl = 5'h00;
      set_req(8'hFF);
      @(negedge clk);
      sw_wr = 1'b0;
      chk(ipl_o == 5'h17, "R10 write ignored while busy", ipl_o, 'h17);
      chk(gnt_id == 3'd3 && din_o, "R9 no resample in data-in", gnt_id, 3);
      set_req('0);
      finish_grant(1'b1, 3);

      // R9: back-to-back grants separated by an idle cycle
      load_ipl(0);
      set_req(8'h10);
      @(negedge clk);
      chk(gnt_valid && gnt_id == 3'd4, "R9 first local grant", gnt_id, 4);
      @(negedge clk);
      chk(!gnt_valid, "R9 idle gap", gnt_valid, 0);
      set_req('0);
      @(negedge clk);
      summary();
   end
endmodule